// File: doc/BRIEF.md
# Satellite Control-Line Reply Receiver

This block listens on the dish control line for a reply coded as bursts of a 22 kHz tone. The comparator output, already sampled into the core clock domain, feeds an edge-based envelope detector. The length of each burst classifies it as one bit. Every nine bits form one byte: eight data bits, most significant first, then a parity bit. Each completed byte goes into an eight-entry FIFO, together with the received parity bit and a flag marking a parity failure.

Reception is armed by a pulse from the local transmitter when its own message ends. After a fixed guard delay the block listens for a reply. The reply either arrives and is closed by a long silence, or it never arrives within the listening window. A status byte packs the FIFO occupancy beside four event flags. A registered interrupt is driven from those flags through a per-flag enable mask. The host drains the FIFO through one read strobe, using two reads per byte. The host may drain while bytes are still arriving.

Top module: `reply_rx`

## Requirements
- R1: After a `txDone` pulse the block ignores all tone for `LISTEN_DELAY` cycles and only then begins listening.
- R2: A tone burst whose envelope lasts more than `THRESH_CYC` cycles decodes as 0, and a shorter one decodes as 1. Each byte is built from eight data bits, MSB first, followed by one parity bit.
- R3: Parity is odd over the nine received bits. The stored error flag is 1 when the count of ones across data and parity is even.
- R4: The FIFO holds up to `DEPTH` (8) bytes. `status[7:4]` shows the count of bytes held, and the count drops by one on the second read of each byte.
- R5: Each byte takes two pulses of `rdEn`. The first leaves the data byte on `rdData`. The second leaves `{6'b0, parityBit, parityError}` and removes the byte. A read of an empty FIFO gives 0 and changes nothing.
- R6: `status[0]` (received) sets when a complete byte has been decoded.
- R7: `status[1]` (complete) sets after `EOM_CYC` cycles of silence that follow at least one byte. Any partial byte left before that silence is discarded.
- R8: `status[3]` (no reply) sets when no tone starts within `NOREPLY_CYC` cycles of listening starting. In that case `status[1]` stays 0.
- R9: A byte that arrives while the FIFO is full is dropped. `status[2]` (overflow) sets and the count stays at `DEPTH`.
- R10: `irq` goes high one cycle after any status bit 0 to 3 is set while `irqMask` has the bit of the same index set. It stays low while that flag's mask bit is 0.
- R11: A `txDone` pulse clears all four flags, empties the FIFO and resets the read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| toneIn | input | 1 | Sampled comparator output of the control line |
| txDone | input | 1 | One-cycle pulse when the local transmission ends |
| rdEn | input | 1 | One-cycle host read strobe on the data register |
| irqMask | input | 4 | Interrupt enable per status flag (bit i gates status[i]) |
| rdData | output | 8 | Registered result of the last read |
| status | output | 8 | {count[3:0], noReply, overflow, complete, received} |
| irq | output | 1 | Registered, masked interrupt request |

## Verification
The embedded assertions watch the FIFO on every cycle. They check that the occupancy never exceeds its depth, that a pop lowers it by exactly one, and that a push into a full FIFO raises the overflow flag without changing the count. They also check that clearing empties the FIFO, that complete and no-reply are never both set, and that `irq` only follows a masked-in flag.

The bench scenarios cover the behaviour that depends on timing. These are the burst-length classification and the parity computation, the guard delay that hides tone sent too early, and the silence and listening-window timeouts. They also cover the order and content of the two-read protocol.

// File: rtl/reply_rx_pkg.sv
package reply_rx_pkg;

  typedef struct packed {
    logic clear;      // new session: wipe flags and FIFO
    logic shift;      // shift bitVal into the data byte
    logic push;       // bitVal is the parity bit: store the byte
    logic bitVal;     // decoded bit value
    logic setDone;    // end of message detected
    logic setNoReply; // listening window expired
  } rxStrobe_t;

  typedef struct packed {
    logic [7:0] data;
    logic       par;
    logic       err;
  } fifoEntry_t;

endpackage

// File: rtl/reply_rx_ctrl.sv
module reply_rx_ctrl
  import reply_rx_pkg::*;
#(
  parameter int ENV_HOLD     = 4,
  parameter int BIT_CYC      = 48,
  parameter int THRESH_CYC   = 24,
  parameter int LISTEN_DELAY = 40,
  parameter int NOREPLY_CYC  = 1500,
  parameter int EOM_CYC      = 160
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      toneIn,
  input  logic      txDone,
  output rxStrobe_t strb
);
  localparam int HW = $clog2(ENV_HOLD + 1);
  localparam int TMAX = (NOREPLY_CYC > LISTEN_DELAY) ? NOREPLY_CYC : LISTEN_DELAY;
  localparam int TW = $clog2(TMAX + 1);
  localparam int CW = $clog2(2 * BIT_CYC + 1);
  localparam int SW = $clog2(EOM_CYC + 1);
  localparam logic [CW-1:0] CMAX = '1;

  typedef enum logic [1:0] {IDLE, WAIT, LISTEN, RX} state_t;

  state_t        st;
  logic          syncA, syncB, envQ;
  logic [HW-1:0] holdCnt;
  logic [TW-1:0] timer;
  logic [CW-1:0] toneCnt;
  logic [SW-1:0] silCnt;
  logic [3:0]    bitCnt;
  logic          gotByte;
  logic          env, rise, fall;

  assign env  = (holdCnt != '0);
  assign rise = env && !envQ;
  assign fall = !env && envQ;

  // envelope: held high while comparator edges keep arriving
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      holdCnt <= '0;
      envQ    <= 1'b0;
    end else begin
      syncA <= toneIn;
      syncB <= syncA;
      envQ  <= env;
      if (syncA != syncB)    holdCnt <= HW'(ENV_HOLD);
      else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    strb            = '0;
    strb.clear      = txDone;
    strb.bitVal     = (toneCnt <= CW'(THRESH_CYC));
    if (!txDone) begin
      strb.setNoReply = (st == LISTEN) && !rise && (timer == TW'(NOREPLY_CYC - 1));
      if (st == RX && fall) begin
        strb.push  = (bitCnt == 4'd8);
        strb.shift = (bitCnt != 4'd8);
      end
      strb.setDone = (st == RX) && !env && (silCnt == SW'(EOM_CYC - 1)) && gotByte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      timer   <= '0;
      toneCnt <= '0;
      silCnt  <= '0;
      bitCnt  <= '0;
      gotByte <= 1'b0;
    end else if (txDone) begin
      st    <= WAIT;
      timer <= '0;
    end else begin
      unique case (st)
        IDLE: ;
        WAIT: begin
          if (timer == TW'(LISTEN_DELAY - 1)) begin
            st    <= LISTEN;
            timer <= '0;
          end else timer <= timer + 1'b1;
        end
        LISTEN: begin
          if (rise) begin
            st      <= RX;
            toneCnt <= CW'(1);
            silCnt  <= '0;
            bitCnt  <= '0;
            gotByte <= 1'b0;
          end else if (timer == TW'(NOREPLY_CYC - 1)) st <= IDLE;
          else timer <= timer + 1'b1;
        end
        RX: begin
          if (env) begin
            silCnt <= '0;
            if (rise) toneCnt <= CW'(1);
            else if (toneCnt != CMAX) toneCnt <= toneCnt + 1'b1;
          end else begin
            silCnt <= silCnt + 1'b1;
            if (silCnt == SW'(EOM_CYC - 1)) st <= IDLE;
          end
          if (fall) begin
            if (bitCnt == 4'd8) begin
              bitCnt  <= '0;
              gotByte <= 1'b1;
            end else bitCnt <= bitCnt + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/reply_rx_dp.sv
module reply_rx_dp
  import reply_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  rxStrobe_t  strb,
  input  logic       rdEn,
  input  logic [3:0] irqMask,
  output logic [7:0] rdData,
  output logic [7:0] status,
  output logic       irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  fifoEntry_t    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic [7:0]    shreg;
  logic          phase;
  logic          fRcvd, fDone, fOvf, fNoRep;
  logic          popNow, pushOk, full;
  logic [3:0]    flags;

  assign full   = (count == CW'(DEPTH));
  assign popNow = rdEn && phase && (count != '0);
  assign pushOk = strb.push && (!full || popNow);
  assign flags  = {fNoRep, fOvf, fDone, fRcvd};
  assign status = {4'(count), flags};

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) begin
      mem[wp].data <= shreg;
      mem[wp].par  <= strb.bitVal;
      mem[wp].err  <= ~(^{shreg, strb.bitVal});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; shreg <= '0; phase <= 1'b0;
      fRcvd <= 1'b0; fDone <= 1'b0; fOvf <= 1'b0; fNoRep <= 1'b0;
      rdData <= '0; irq <= 1'b0;
    end else if (strb.clear) begin
      wp <= '0; rp <= '0; count <= '0; shreg <= '0; phase <= 1'b0;
      fRcvd <= 1'b0; fDone <= 1'b0; fOvf <= 1'b0; fNoRep <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (strb.shift) shreg <= {shreg[6:0], strb.bitVal};
      if (strb.push) fRcvd <= 1'b1;
      if (strb.push && !pushOk) fOvf <= 1'b1;
      if (strb.setDone) fDone <= 1'b1;
      if (strb.setNoReply) fNoRep <= 1'b1;
      if (pushOk) wp <= nextPtr(wp);
      if (popNow) rp <= nextPtr(rp);
      if (pushOk && !popNow) count <= count + 1'b1;
      else if (popNow && !pushOk) count <= count - 1'b1;
      if (rdEn) begin
        if (count == '0) begin
          rdData <= '0;
        end else if (!phase) begin
          rdData <= mem[rp].data;
          phase  <= 1'b1;
        end else begin
          rdData <= {6'b0, mem[rp].par, mem[rp].err};
          phase  <= 1'b0;
        end
      end
      irq <= |(flags & irqMask);
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r4_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && phase && count != '0 && !strb.push && !strb.clear) |=> count == $past(count) - 1'b1);

  a_r9_overflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.push && full && !(rdEn && phase) && !strb.clear) |=> (fOvf && count == CW'(DEPTH)));

  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> (count == '0 && status[3:0] == 4'b0));

  a_r7_done_vs_noreply: assert property (@(posedge clk) disable iff (!rst_n)
    !(fDone && fNoRep));

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(status[3:0] & irqMask)));

endmodule

// File: rtl/reply_rx.sv
module reply_rx
  import reply_rx_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int ENV_HOLD     = 4,
  parameter int BIT_CYC      = 48,
  parameter int THRESH_CYC   = 24,
  parameter int LISTEN_DELAY = 40,
  parameter int NOREPLY_CYC  = 1500,
  parameter int EOM_CYC      = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       toneIn,
  input  logic       txDone,
  input  logic       rdEn,
  input  logic [3:0] irqMask,
  output logic [7:0] rdData,
  output logic [7:0] status,
  output logic       irq
);
  rxStrobe_t strb;

  reply_rx_ctrl #(
    .ENV_HOLD(ENV_HOLD), .BIT_CYC(BIT_CYC), .THRESH_CYC(THRESH_CYC),
    .LISTEN_DELAY(LISTEN_DELAY), .NOREPLY_CYC(NOREPLY_CYC), .EOM_CYC(EOM_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .toneIn(toneIn), .txDone(txDone), .strb(strb)
  );

  reply_rx_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .rdEn(rdEn), .irqMask(irqMask),
    .rdData(rdData), .status(status), .irq(irq)
  );

endmodule

// File: tb/reply_rx_tb.sv
module reply_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       toneIn = 1'b0;
  logic       txDone = 1'b0;
  logic       rdEn = 1'b0;
  logic [3:0] irqMask = 4'b0;
  logic [7:0] rdData, status;
  logic       irq;
  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  reply_rx u_dut (
    .clk(clk), .rst_n(rst_n), .toneIn(toneIn), .txDone(txDone), .rdEn(rdEn),
    .irqMask(irqMask), .rdData(rdData), .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTx();
    @(negedge clk) txDone = 1'b1;
    @(negedge clk) txDone = 1'b0;
  endtask

  task automatic readOnce(output logic [7:0] v);
    @(negedge clk) rdEn = 1'b1;
    @(negedge clk) rdEn = 1'b0;
    v = rdData;
  endtask

  // burst of n comparator toggles followed by silence to fill a 48-cycle bit
  task automatic sendBit(input logic b);
    int n = b ? 12 : 32;
    repeat (n) @(negedge clk) toneIn = ~toneIn;
    idle(48 - n);
  endtask

  task automatic sendByte(input logic [7:0] d, input logic p);
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    sendBit(p);
  endtask

  task automatic testReset();
    check("R11 reset status", status, 8'h00);
    check("R10 reset irq", {7'b0, irq}, 8'h00);
    check("R5 reset rdData", rdData, 8'h00);
  endtask

  task automatic testNoReply();
    irqMask = 4'b1000;
    pulseTx();
    repeat (12) @(negedge clk) toneIn = ~toneIn; // tone inside guard delay: R1
    idle(1600);
    check("R8/R1 no reply status", status, 8'h08);
    check("R10 irq on no reply", {7'b0, irq}, 8'h01);
  endtask

  task automatic testMessage();
    logic [7:0] v;
    irqMask = 4'b0000;
    pulseTx();
    idle(2);
    check("R11 flags cleared", status, 8'h00);
    idle(50);
    sendByte(8'hA5, 1'b1);
    check("R6 received after first byte", status, 8'h11);
    sendByte(8'h3C, 1'b0);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); // partial byte
    idle(200);
    check("R7 complete, partial dropped", status, 8'h23);
    check("R10 masked irq stays low", {7'b0, irq}, 8'h00);
    readOnce(v); check("R5 R2 first read data", v, 8'hA5);
    check("R4 count kept after first read", status, 8'h23);
    readOnce(v); check("R5 R3 second read good parity", v, 8'h02);
    check("R4 count after pop", status, 8'h13);
    readOnce(v); check("R2 second byte data", v, 8'h3C);
    readOnce(v); check("R3 parity error flagged", v, 8'h01);
    check("R4 empty", status, 8'h03);
    readOnce(v); check("R5 empty read", v, 8'h00);
    check("R5 empty read no change", status, 8'h03);
  endtask

  task automatic testOverflow();
    logic [7:0] v;
    irqMask = 4'b0100;
    pulseTx();
    idle(50);
    for (int i = 0; i < 9; i++) sendByte(8'(i * 17), ~(^(8'(i * 17))));
    check("R9 overflow status", status, 8'h85);
    check("R10 irq on overflow", {7'b0, irq}, 8'h01);
    for (int i = 0; i < 8; i++) begin
      readOnce(v); check("R9 R4 kept bytes in order", v, 8'(i * 17));
      readOnce(v); check("R3 good parity", v, 8'h02);
    end
    check("R9 ninth byte dropped", status[7:4] == 4'd0 ? 8'h00 : {4'b0, status[7:4]}, 8'h00);
    pulseTx();
    idle(2);
    check("R11 clear after overflow", status, 8'h00);
    check("R11 irq cleared", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    testReset();
    testNoReply();
    testMessage();
    testOverflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule